// File: doc/BRIEF.md
# Predicated Integer-to-Condition-Field Vector Writer

This block expands one vector operation into a run of condition-field writes, one element per clock. Element i targets condition field `fld_base + i`. Each element's four-bit value is built from a single source bit, which comes from the integer side, and a four-bit lane mask and a four-bit lane mode. Lane j of the field is set when its mask bit is set and its mode bit equals the source bit.

A 64-bit destination predicate decides, element by element, how the target field is treated. A set predicate bit means the field is computed. A clear bit means the field is either zeroed, when destination zeroing is on, or left untouched. An optional source predicate, which may be inverted, can also force the source bit to zero when source zeroing is on.

When the source register is register zero, every source bit is zero. Each enabled element then receives `mask & ~mode`. In effect this copies the integer predicate into a run of condition fields. Register-file storage and instruction decode sit outside the block. The block drives a single write port for condition fields.

Top module: `pred_cond_writer`

## Requirements
- R1: After reset, `busy`, `wr_en` and `done` are low, and `wr_en` stays low whenever `busy` is low.
- R2: A `start` seen while idle captures all operands. In the clock cycles that follow, elements 0, 1, … VL-1 are presented one per cycle in ascending order. Element i addresses field `(fld_base + i)` modulo 2^FIDX_W.
- R3: When destination predicate bit i is 1, element i is written (`wr_en` high), and `wr_data[j] = op_mask[j] & (op_mode[j] == s)`, where s is the element's source bit.
- R4: When destination predicate bit i is 0 and `dpred_zero` is 1, element i is written with `wr_data = 4'b0000`. The source and the source predicate have no effect in this case.
- R5: When destination predicate bit i is 0 and `dpred_zero` is 0, `wr_en` stays low in that element's cycle. Stepping continues with the next element.
- R6: When `src_reg_zero` is 1, s is 0 for every element, so enabled elements receive `op_mask & ~op_mode`. With mask 0011, mode 0000, dpred 0b10 and zeroing on, field base+0 receives 0000 and field base+1 receives 0011.
- R7: When `src_is_vec` is 1, s for element i is `src_elem_lsbs[i]`, the least significant bit of integer element i. When it is 0, s is `src_scalar_bit` for every element.
- R8: When `spred_en` is 1, the effective source predicate bit is `spred[i] ^ spred_inv`. If that bit is 0 and `spred_zero` is 1, s is forced to 0. In every other case the source predicate leaves s unchanged.
- R9: `done` pulses high for one cycle, in the cycle after element VL-1 is presented, with `busy` low. With VL = 0, `done` pulses in the cycle after `start` and no write occurs. A VL above 64 is treated as 64.
- R10: A `start` asserted while `busy` is high is ignored. The running operation continues with its captured operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| vl | input | 7 | Element count, 0 to 64 |
| fld_base | input | 7 | First condition field number |
| op_mask | input | 4 | Lane mask |
| op_mode | input | 4 | Lane compare values |
| src_is_vec | input | 1 | 1: per-element source bits, 0: scalar source bit |
| src_reg_zero | input | 1 | Source register is register zero |
| src_scalar_bit | input | 1 | Scalar source bit |
| src_elem_lsbs | input | 64 | LSB of each integer source element |
| spred_en | input | 1 | Source predicate in use |
| spred_inv | input | 1 | Invert the source predicate |
| spred_zero | input | 1 | Source zeroing |
| spred | input | 64 | Source predicate |
| dpred | input | 64 | Destination predicate |
| dpred_zero | input | 1 | Destination zeroing |
| busy | output | 1 | Operation in progress |
| wr_en | output | 1 | Condition-field write strobe |
| wr_idx | output | 7 | Condition-field number being written |
| wr_data | output | 4 | Field value being written |
| done | output | 1 | One-cycle completion pulse |

## Verification
Destination zeroing and source zeroing can both apply to the same element: the destination predicate bit is 0 with `dpred_zero` set, while the source predicate bit is also 0 with `spred_zero` set. The bench provokes this by drawing both predicates and all zeroing flags at random, and also through directed runs with all-zero predicates. The expected value is taken from the destination rule alone: the element must be written as 0000, and the source side must not turn it into a skipped write or a mask-derived value. A second collision, a new `start` pulsed in the middle of a run, is checked by confirming that every later write still matches the operands captured at the first start.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  localparam int FLD_W = 4;

  typedef struct packed {
    logic [FLD_W-1:0] mask;
    logic [FLD_W-1:0] mode;
    logic             src_vec;
    logic             src_zero;
    logic             src_scalar;
    logic             sp_en;
    logic             sp_inv;
    logic             sp_zero;
    logic             dst_zero;
  } pcw_cfg_t;
endpackage

// File: rtl/pcw_seq.sv
module pcw_seq #(
  parameter int MAX_VL = 64,
  localparam int ELEM_W = $clog2(MAX_VL),
  localparam int VL_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VL_W-1:0]   vl_in,
  output logic              busy,
  output logic [ELEM_W-1:0] elem,
  output logic              load,
  output logic              done
);
  logic              busy_q, busy_n;
  logic [ELEM_W-1:0] elem_q, elem_n;
  logic [VL_W-1:0]   vl_q, vl_n, vl_c;
  logic              done_q, done_n;
  logic              last;

  assign vl_c = (vl_in > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_in;
  assign last = (VL_W'(elem_q) + VL_W'(1)) == vl_q;
  assign load = start & ~busy_q;

  always_comb begin
    busy_n = busy_q;
    elem_n = elem_q;
    vl_n   = vl_q;
    done_n = 1'b0;
    if (load) begin
      elem_n = '0;
      vl_n   = vl_c;
      if (vl_c == '0) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end else begin
        busy_n = 1'b1;
      end
    end else if (busy_q) begin
      if (last) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end else begin
        elem_n = elem_q + ELEM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      elem_q <= '0;
      vl_q   <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      if (load || busy_q) begin
        elem_q <= elem_n;
        vl_q   <= vl_n;
      end
    end
  end

  assign busy = busy_q;
  assign elem = elem_q;
  assign done = done_q;

  // element counter advances by one while a run continues
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (busy_q && elem_q == $past(elem_q) + ELEM_W'(1)));

  // completion pulse only while idle
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // captured length cannot be replaced mid-run
  assert_hold_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> $stable(vl_q));
endmodule

// File: rtl/pcw_sel.sv
module pcw_sel
  import pcw_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int ELEM_W = $clog2(MAX_VL)
) (
  input  logic              busy,
  input  logic [ELEM_W-1:0] elem,
  input  pcw_cfg_t          cfg,
  input  logic [MAX_VL-1:0] src_lsbs,
  input  logic [MAX_VL-1:0] spred,
  input  logic [MAX_VL-1:0] dpred,
  output logic              wr_en,
  output logic              kill,
  output logic              sbit
);
  logic dbit;
  logic sp_bit;
  logic raw;

  always_comb begin
    dbit   = dpred[elem];
    sp_bit = spred[elem] ^ cfg.sp_inv;
    if (cfg.src_zero)
      raw = 1'b0;
    else if (cfg.src_vec)
      raw = src_lsbs[elem];
    else
      raw = cfg.src_scalar;
    sbit  = (cfg.sp_en && !sp_bit && cfg.sp_zero) ? 1'b0 : raw;
    kill  = ~dbit;
    wr_en = busy & (dbit | cfg.dst_zero);
  end
endmodule

// File: rtl/pcw_field.sv
module pcw_field
  import pcw_pkg::*;
(
  input  logic [FLD_W-1:0] mask,
  input  logic [FLD_W-1:0] mode,
  input  logic             sbit,
  input  logic             kill,
  output logic [FLD_W-1:0] data
);
  for (genvar j = 0; j < FLD_W; j++) begin : g_lane
    assign data[j] = ~kill & mask[j] & ~(mode[j] ^ sbit);
  end
endmodule

// File: rtl/pred_cond_writer.sv
module pred_cond_writer
  import pcw_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int FIDX_W = 7,
  localparam int ELEM_W = $clog2(MAX_VL),
  localparam int VL_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VL_W-1:0]   vl,
  input  logic [FIDX_W-1:0] fld_base,
  input  logic [FLD_W-1:0]  op_mask,
  input  logic [FLD_W-1:0]  op_mode,
  input  logic              src_is_vec,
  input  logic              src_reg_zero,
  input  logic              src_scalar_bit,
  input  logic [MAX_VL-1:0] src_elem_lsbs,
  input  logic              spred_en,
  input  logic              spred_inv,
  input  logic              spred_zero,
  input  logic [MAX_VL-1:0] spred,
  input  logic [MAX_VL-1:0] dpred,
  input  logic              dpred_zero,
  output logic              busy,
  output logic              wr_en,
  output logic [FIDX_W-1:0] wr_idx,
  output logic [FLD_W-1:0]  wr_data,
  output logic              done
);
  logic              load;
  logic [ELEM_W-1:0] elem;
  pcw_cfg_t          cfg_q, cfg_n;
  logic [FIDX_W-1:0] base_q;
  logic [MAX_VL-1:0] lsbs_q, spred_q, dpred_q;
  logic              kill, sbit, en_c;

  pcw_seq #(.MAX_VL(MAX_VL)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl),
    .busy(busy), .elem(elem), .load(load), .done(done)
  );

  always_comb begin
    cfg_n.mask       = op_mask;
    cfg_n.mode       = op_mode;
    cfg_n.src_vec    = src_is_vec;
    cfg_n.src_zero   = src_reg_zero;
    cfg_n.src_scalar = src_scalar_bit;
    cfg_n.sp_en      = spred_en;
    cfg_n.sp_inv     = spred_inv;
    cfg_n.sp_zero    = spred_zero;
    cfg_n.dst_zero   = dpred_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      base_q  <= '0;
      lsbs_q  <= '0;
      spred_q <= '0;
      dpred_q <= '0;
    end else if (load) begin
      cfg_q   <= cfg_n;
      base_q  <= fld_base;
      lsbs_q  <= src_elem_lsbs;
      spred_q <= spred;
      dpred_q <= dpred;
    end
  end

  pcw_sel #(.MAX_VL(MAX_VL)) u_sel (
    .busy(busy), .elem(elem), .cfg(cfg_q), .src_lsbs(lsbs_q),
    .spred(spred_q), .dpred(dpred_q),
    .wr_en(en_c), .kill(kill), .sbit(sbit)
  );

  pcw_field u_field (
    .mask(cfg_q.mask), .mode(cfg_q.mode), .sbit(sbit), .kill(kill),
    .data(wr_data)
  );

  assign wr_en  = en_c;
  assign wr_idx = base_q + FIDX_W'(elem);

  // no write strobe outside a run
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);

  // a written field never sets a lane outside the captured mask
  assert_mask_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_data & ~cfg_q.mask) == '0));
endmodule

// File: tb/sim_pred_cond_writer.sv
module sim_pred_cond_writer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [6:0]  vl;
  logic [6:0]  fld_base;
  logic [3:0]  op_mask, op_mode;
  logic        src_is_vec, src_reg_zero, src_scalar_bit;
  logic [63:0] src_elem_lsbs;
  logic        spred_en, spred_inv, spred_zero;
  logic [63:0] spred, dpred;
  logic        dpred_zero;
  logic        busy, wr_en, done;
  logic [6:0]  wr_idx;
  logic [3:0]  wr_data;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pred_cond_writer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .fld_base(fld_base),
    .op_mask(op_mask), .op_mode(op_mode), .src_is_vec(src_is_vec),
    .src_reg_zero(src_reg_zero), .src_scalar_bit(src_scalar_bit),
    .src_elem_lsbs(src_elem_lsbs), .spred_en(spred_en), .spred_inv(spred_inv),
    .spred_zero(spred_zero), .spred(spred), .dpred(dpred),
    .dpred_zero(dpred_zero), .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .done(done)
  );

  // snapshot of operands for expected values
  logic [6:0]  s_base;
  logic [3:0]  s_mask, s_mode;
  logic        s_vec, s_rz, s_sc, s_spen, s_spinv, s_spz, s_dz;
  logic [63:0] s_lsbs, s_sp, s_dp;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic src_of(input int i);
    logic s;
    logic p;
    s = s_rz ? 1'b0 : (s_vec ? s_lsbs[i] : s_sc);
    p = s_sp[i] ^ s_spinv;
    if (s_spen && !p && s_spz) s = 1'b0;
    return s;
  endfunction

  function automatic logic exp_en(input int i);
    return s_dp[i] | s_dz;
  endfunction

  function automatic logic [3:0] exp_data(input int i);
    logic [3:0] d;
    logic s;
    if (!s_dp[i]) return 4'b0000;
    s = src_of(i);
    for (int j = 0; j < 4; j++) d[j] = s_mask[j] & (s_mode[j] == s);
    return d;
  endfunction

  // drives start with current inputs; poke pulses a competing start mid-run
  task automatic run_op(input bit poke);
    int n;
    s_base = fld_base; s_mask = op_mask; s_mode = op_mode;
    s_vec = src_is_vec; s_rz = src_reg_zero; s_sc = src_scalar_bit;
    s_spen = spred_en; s_spinv = spred_inv; s_spz = spred_zero;
    s_dz = dpred_zero; s_lsbs = src_elem_lsbs; s_sp = spred; s_dp = dpred;
    n = (vl > 7'd64) ? 64 : int'(vl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      check("R2", {31'd0, busy}, 32'd1, "busy during run");
      if (exp_en(i)) begin
        check(s_dp[i] ? "R3" : "R4", {31'd0, wr_en}, 32'd1, "write strobe");
        check("R2", {25'd0, wr_idx}, {25'd0, 7'(s_base + 7'(i))}, "field index");
        check(s_dp[i] ? (s_rz ? "R6" : (s_spen ? "R8" : "R7")) : "R4",
              {28'd0, wr_data}, {28'd0, exp_data(i)}, "field data");
      end else begin
        check("R5", {31'd0, wr_en}, 32'd0, "skipped element");
      end
      if (poke && i == 1) begin
        start = 1'b1;
        op_mask = ~op_mask; op_mode = ~op_mode; dpred = ~dpred;
        fld_base = fld_base + 7'd33; vl = 7'd64;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(poke ? "R10" : "R9", {31'd0, done}, 32'd1, "done pulse");
    check("R9", {31'd0, busy}, 32'd0, "idle at done");
    check("R1", {31'd0, wr_en}, 32'd0, "no write at done");
    @(negedge clk);
    check("R9", {31'd0, done}, 32'd0, "done is one cycle");
  endtask

  task automatic randomize_ops();
    fld_base = 7'($urandom);
    op_mask = 4'($urandom); op_mode = 4'($urandom);
    src_is_vec = 1'($urandom); src_reg_zero = ($urandom % 4) == 0;
    src_scalar_bit = 1'($urandom);
    src_elem_lsbs = {$urandom, $urandom};
    spred_en = 1'($urandom); spred_inv = 1'($urandom); spred_zero = 1'($urandom);
    spred = {$urandom, $urandom}; dpred = {$urandom, $urandom};
    dpred_zero = 1'($urandom);
    vl = 7'($urandom % 20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0;
    randomize_ops();
    repeat (3) @(negedge clk);
    check("R1", {31'd0, busy}, 32'd0, "busy in reset");
    check("R1", {31'd0, wr_en}, 32'd0, "wr_en in reset");
    check("R1", {31'd0, done}, 32'd0, "done in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {31'd0, wr_en}, 32'd0, "wr_en after reset");

    // R6: register-zero source example
    fld_base = 7'd8; op_mask = 4'b0011; op_mode = 4'b0000;
    src_reg_zero = 1'b1; spred_en = 1'b0; dpred = 64'b10; dpred_zero = 1'b1;
    vl = 7'd2;
    run_op(0);

    // R5: no zeroing, sparse predicate
    dpred = 64'h5; dpred_zero = 1'b0; vl = 7'd4;
    run_op(0);

    // R4 with R8: both zeroings on the same elements
    dpred = 64'h0; dpred_zero = 1'b1; spred_en = 1'b1; spred = 64'h0;
    spred_inv = 1'b0; spred_zero = 1'b1; src_reg_zero = 1'b0;
    src_is_vec = 1'b0; src_scalar_bit = 1'b1; op_mask = 4'hF; vl = 7'd3;
    run_op(0);

    // R8: inverted source predicate forcing zero
    dpred = 64'hF; spred = 64'hA; spred_inv = 1'b1; op_mode = 4'b0101;
    run_op(0);

    // R7: vector source
    spred_en = 1'b0; src_is_vec = 1'b1; src_elem_lsbs = 64'hC3; vl = 7'd8;
    dpred = 64'hFF; op_mode = 4'b1001;
    run_op(0);

    // R9: zero length, and full length with wrap of the field index
    vl = 7'd0;
    run_op(0);
    fld_base = 7'd100; vl = 7'd64; dpred = {$urandom, $urandom};
    run_op(0);
    // R9: length above the maximum is clamped
    fld_base = 7'd5; vl = 7'd100;
    run_op(0);

    // R10: start during a run is ignored
    randomize_ops(); vl = 7'd6;
    run_op(1);

    for (int k = 0; k < 60; k++) begin
      randomize_ops();
      run_op(k % 10 == 3 && vl > 7'd2);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule